// File: doc/BRIEF.md
# Performance-Monitor ID Register Read Gate

This block decides what happens when software asks to read the identification word of one instance in a bank of system performance monitors. It receives the requesting privilege level, the debug state, which optional privilege levels and features exist, the monitor enable bits, two per-instance permission vectors, the instance select and the ID words of all instances. One clock after a request it returns one of four results: the ID word is read, the instruction is undefined, the access traps to the second privilege level, or the access traps to the third privilege level.

The checks form a fixed priority chain. The first check that fails sets the result. Traps report a fixed syndrome class. A halted core with secure debug disabled turns a denial aimed at the third level into an undefined instruction. Instruction decode and exception entry belong to the surrounding core. The returned word is sanitised so that its reserved bits read as zero.

Top module: `spmu_id_access_gate`

## Requirements
- R1: A request at privilege level 0 (`cur_el` = 0) always yields the result undefined.
- R2: A request at privilege level 3 always yields read-ok with the selected instance's ID word, whatever the enables and permissions are.
- R3: The permission for instance s is bits [2s+1:2s] of `perm_l2` and `perm_l3`. The value 00 denies access. A select of `N_INST` or more is treated as permission 00 and returns zero data.
- R4: At level 1 the result is the first failing check in this order: (a) early-undefined checks, see R6; (b) trap-L2 if the fine-grained trap feature and level 3 both exist and `fgt_en_l3` = 0; (c) trap-L2 if the fine-grained trap feature exists and `fgt_rd_allow` = 0; (d) trap-L2 if `mon_en_l2` = 0; (e) trap-L2 if the L2 permission is 00; (f) level-3 denial if level 3 exists and `mon_en_l3` = 0; (g) level-3 denial if level 3 exists and the L3 permission is 00. If no check fails, the result is read-ok.
- R5: Checks (b) to (e) apply only when `l2_enabled` = 1. At level 2 only checks (a), (f) and (g) run, in that order.
- R6: Let hsd mean `halted`, `has_l3` and `sec_dbg_dis` are all 1. A level-3 denial from (f) or (g) gives undefined when `halted` and `sec_dbg_dis` are both 1, and trap-L3 otherwise. When hsd and `early_undef_opt` are both 1, (f) and (g) are tested first at step (a) and yield undefined.
- R7: `rsp_outcome` encodes 00 read-ok, 01 undefined, 10 trap-L2, 11 trap-L3. `rsp_ec` is 0x18 on either trap and 0 otherwise.
- R8: On read-ok, `rsp_data` is the selected ID word with bits 63:32 and bit 7 forced to zero. Bits 31:20 are the product, 19:16 the variant, 15:12 the revision, and 11:8 together with 6:0 the designer code (for example 0x43B). On any other result `rsp_data` is zero. An all-zero word marks an instance that is not implemented and is passed through unchanged.
- R9: A request sampled at a rising edge with `req_valid` = 1 is answered at that edge with `rsp_valid` = 1. Without a request, all response outputs are zero after the edge.
- R10: While `rst_n` is low, all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| cur_el | input | 2 | Requesting privilege level 0..3 |
| halted | input | 1 | Core is in debug halt |
| sec_dbg_dis | input | 1 | Secure debug disabled |
| has_l3 | input | 1 | Privilege level 3 exists |
| l2_enabled | input | 1 | Privilege level 2 enabled in current state |
| has_fgt | input | 1 | Fine-grained trap feature exists |
| early_undef_opt | input | 1 | Implementation option: early undefined when halted |
| fgt_en_l3 | input | 1 | Level-3 enable for fine-grained traps |
| fgt_rd_allow | input | 1 | Fine-grained read allow bit (0 traps) |
| mon_en_l2 | input | 1 | Level-2 monitor access enable |
| mon_en_l3 | input | 1 | Level-3 monitor access enable |
| perm_l2 | input | 2*N_INST | Level-2 per-instance permissions |
| perm_l3 | input | 2*N_INST | Level-3 per-instance permissions |
| inst_sel | input | SEL_W | Instance select |
| id_words | input | 64*N_INST | ID word of every instance, instance 0 lowest |
| rsp_valid | output | 1 | Response present |
| rsp_outcome | output | 2 | Result code |
| rsp_ec | output | 6 | Trap syndrome class |
| rsp_data | output | 64 | Read data |

## Verification
A wrong priority step shows up as a wrong result code on the response that follows the offending request. For example, a trap-L2 is returned where the order calls for undefined, or a trap-L3 where the halt rule calls for undefined. Each request is checked on its own, so a single bad decision is seen one cycle after it is sampled. A slicing error in the permission vectors or the ID array shows as a denial for the wrong instance, or as data from a neighbouring instance. A missing mask shows as nonzero reserved bits on the first read-ok with ones in those positions.

// File: rtl/spmu_gate_pkg.sv
package spmu_gate_pkg;

    localparam int ID_W = 64;
    localparam int EC_W = 6;
    localparam logic [EC_W-1:0] TRAP_EC = 6'h18;

    // Reserved positions of the ID word: upper half and bit 7.
    localparam logic [ID_W-1:0] ID_KEEP_MASK = 64'h0000_0000_FFFF_FF7F;

    typedef enum logic [1:0] {
        OC_READ  = 2'b00,
        OC_UNDEF = 2'b01,
        OC_TRAP2 = 2'b10,
        OC_TRAP3 = 2'b11
    } outcome_e;

    typedef struct packed {
        logic            vld;
        outcome_e        oc;
        logic [EC_W-1:0] ec;
        logic [ID_W-1:0] data;
    } rsp_t;

endpackage

// File: rtl/spmu_perm_slice.sv
module spmu_perm_slice #(
    parameter int N_INST = 4,
    parameter int SEL_W  = 3
) (
    input  logic [2*N_INST-1:0] perm_vec,
    input  logic [SEL_W-1:0]    sel,
    output logic                denied
);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(N_INST - 1);

    logic [N_INST-1:0] open_v;

    for (genvar g = 0; g < N_INST; g++) begin : g_open
        assign open_v[g] = |perm_vec[2*g +: 2];
    end

    always_comb begin
        denied = 1'b1;
        for (int i = 0; i < N_INST; i++) begin
            if (sel == SEL_W'(i)) begin
                denied = !open_v[i];
            end
        end
        if (sel > LAST_SEL) begin
            denied = 1'b1;
        end
    end

endmodule

// File: rtl/spmu_id_mux.sv
module spmu_id_mux
    import spmu_gate_pkg::*;
#(
    parameter int N_INST = 4,
    parameter int SEL_W  = 3
) (
    input  logic [ID_W*N_INST-1:0] id_words,
    input  logic [SEL_W-1:0]       sel,
    output logic [ID_W-1:0]        id_clean
);
    logic [ID_W-1:0] word_v [N_INST];

    for (genvar g = 0; g < N_INST; g++) begin : g_word
        assign word_v[g] = id_words[ID_W*g +: ID_W] & ID_KEEP_MASK;
    end

    always_comb begin
        id_clean = '0;
        for (int i = 0; i < N_INST; i++) begin
            if (sel == SEL_W'(i)) begin
                id_clean = word_v[i];
            end
        end
    end

endmodule

// File: rtl/spmu_gate_chain.sv
module spmu_gate_chain
    import spmu_gate_pkg::*;
(
    input  logic [1:0] cur_el,
    input  logic       halted,
    input  logic       sec_dbg_dis,
    input  logic       has_l3,
    input  logic       l2_enabled,
    input  logic       has_fgt,
    input  logic       early_undef_opt,
    input  logic       fgt_en_l3,
    input  logic       fgt_rd_allow,
    input  logic       mon_en_l2,
    input  logic       mon_en_l3,
    input  logic       deny_l2,
    input  logic       deny_l3,
    output outcome_e   outcome
);
    logic hsd_early;
    logic l3_deny_any;
    logic l2_deny_any;
    outcome_e l3_verdict;

    always_comb begin
        hsd_early   = halted && has_l3 && sec_dbg_dis && early_undef_opt;
        l3_deny_any = has_l3 && (!mon_en_l3 || deny_l3);
        l2_deny_any = l2_enabled && (
                          (has_fgt && has_l3 && !fgt_en_l3) ||
                          (has_fgt && !fgt_rd_allow) ||
                          !mon_en_l2 ||
                          deny_l2);
        l3_verdict  = (halted && sec_dbg_dis) ? OC_UNDEF : OC_TRAP3;
    end

    always_comb begin
        outcome = OC_READ;
        unique case (cur_el)
            2'd0: outcome = OC_UNDEF;
            2'd1: begin
                if (hsd_early && (!mon_en_l3 || deny_l3)) begin
                    outcome = OC_UNDEF;
                end else if (l2_deny_any) begin
                    outcome = OC_TRAP2;
                end else if (l3_deny_any) begin
                    outcome = l3_verdict;
                end
            end
            2'd2: begin
                if (hsd_early && (!mon_en_l3 || deny_l3)) begin
                    outcome = OC_UNDEF;
                end else if (l3_deny_any) begin
                    outcome = l3_verdict;
                end
            end
            default: outcome = OC_READ;
        endcase
    end

endmodule

// File: rtl/spmu_id_access_gate.sv
module spmu_id_access_gate
    import spmu_gate_pkg::*;
#(
    parameter int N_INST = 4,
    parameter int SEL_W  = $clog2(N_INST) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             cur_el,
    input  logic                   halted,
    input  logic                   sec_dbg_dis,
    input  logic                   has_l3,
    input  logic                   l2_enabled,
    input  logic                   has_fgt,
    input  logic                   early_undef_opt,
    input  logic                   fgt_en_l3,
    input  logic                   fgt_rd_allow,
    input  logic                   mon_en_l2,
    input  logic                   mon_en_l3,
    input  logic [2*N_INST-1:0]    perm_l2,
    input  logic [2*N_INST-1:0]    perm_l3,
    input  logic [SEL_W-1:0]       inst_sel,
    input  logic [64*N_INST-1:0]   id_words,
    output logic                   rsp_valid,
    output logic [1:0]             rsp_outcome,
    output logic [5:0]             rsp_ec,
    output logic [63:0]            rsp_data
);
    localparam logic [SEL_W-1:0] N_SEL = SEL_W'(N_INST);

    logic            deny_l2;
    logic            deny_l3;
    logic [ID_W-1:0] id_clean;
    outcome_e        oc;
    rsp_t            rsp_d;
    rsp_t            rsp_q;

    spmu_perm_slice #(.N_INST(N_INST), .SEL_W(SEL_W)) perm2_i (
        .perm_vec (perm_l2),
        .sel      (inst_sel),
        .denied   (deny_l2)
    );

    spmu_perm_slice #(.N_INST(N_INST), .SEL_W(SEL_W)) perm3_i (
        .perm_vec (perm_l3),
        .sel      (inst_sel),
        .denied   (deny_l3)
    );

    spmu_id_mux #(.N_INST(N_INST), .SEL_W(SEL_W)) mux_i (
        .id_words (id_words),
        .sel      (inst_sel),
        .id_clean (id_clean)
    );

    spmu_gate_chain chain_i (
        .cur_el          (cur_el),
        .halted          (halted),
        .sec_dbg_dis     (sec_dbg_dis),
        .has_l3          (has_l3),
        .l2_enabled      (l2_enabled),
        .has_fgt         (has_fgt),
        .early_undef_opt (early_undef_opt),
        .fgt_en_l3       (fgt_en_l3),
        .fgt_rd_allow    (fgt_rd_allow),
        .mon_en_l2       (mon_en_l2),
        .mon_en_l3       (mon_en_l3),
        .deny_l2         (deny_l2),
        .deny_l3         (deny_l3),
        .outcome         (oc)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.vld  = 1'b1;
            rsp_d.oc   = oc;
            rsp_d.ec   = (oc == OC_TRAP2 || oc == OC_TRAP3) ? TRAP_EC : '0;
            rsp_d.data = (oc == OC_READ) ? id_clean : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid   = rsp_q.vld;
    assign rsp_outcome = rsp_q.oc;
    assign rsp_ec      = rsp_q.ec;
    assign rsp_data    = rsp_q.data;

    // R1
    a_r1_low_level_undef: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cur_el == 2'd0 |=> rsp_outcome == 2'b01);

    // R2
    a_r2_top_level_reads: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cur_el == 2'd3 |=> rsp_outcome == 2'b00);

    // R3
    a_r3_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && inst_sel >= N_SEL |=> rsp_data == 64'h0);

    // R6
    a_r6_halt_no_l3_trap: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && halted && sec_dbg_dis |=> rsp_outcome != 2'b11);

    // R7
    a_r7_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_outcome[1] |-> rsp_ec == 6'h18);

    // R8
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_data[63:32] == 32'h0 && !rsp_data[7]);

    // R8
    a_r8_no_data_unless_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_outcome != 2'b00 |-> rsp_data == 64'h0);

    // R9
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && rsp_outcome == 2'b00 && rsp_ec == 6'h0);

endmodule

// File: tb/spmu_id_access_gate_tb.sv
`timescale 1ns/1ps
module spmu_id_access_gate_tb_top;

    localparam int N  = 4;
    localparam int SW = $clog2(N) + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [1:0]      cur_el = '0;
    logic            halted = 1'b0, sec_dbg_dis = 1'b0, has_l3 = 1'b1;
    logic            l2_enabled = 1'b1, has_fgt = 1'b1, early_undef_opt = 1'b0;
    logic            fgt_en_l3 = 1'b1, fgt_rd_allow = 1'b1;
    logic            mon_en_l2 = 1'b1, mon_en_l3 = 1'b1;
    logic [2*N-1:0]  perm_l2 = '1, perm_l3 = '1;
    logic [SW-1:0]   inst_sel = '0;
    logic [64*N-1:0] id_words = '0;
    logic            rsp_valid;
    logic [1:0]      rsp_outcome;
    logic [5:0]      rsp_ec;
    logic [63:0]     rsp_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spmu_id_access_gate #(.N_INST(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_el(cur_el),
        .halted(halted), .sec_dbg_dis(sec_dbg_dis), .has_l3(has_l3),
        .l2_enabled(l2_enabled), .has_fgt(has_fgt), .early_undef_opt(early_undef_opt),
        .fgt_en_l3(fgt_en_l3), .fgt_rd_allow(fgt_rd_allow),
        .mon_en_l2(mon_en_l2), .mon_en_l3(mon_en_l3),
        .perm_l2(perm_l2), .perm_l3(perm_l3), .inst_sel(inst_sel),
        .id_words(id_words), .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome),
        .rsp_ec(rsp_ec), .rsp_data(rsp_data)
    );

    function automatic logic [1:0] slice(input logic [2*N-1:0] v, input int s);
        if (s >= N) return 2'b00;
        return v[2*s +: 2];
    endfunction

    // Reference: outcome 0 read, 1 undef, 2 trap-L2, 3 trap-L3
    function automatic logic [1:0] ref_outcome();
        int  s = int'(inst_sel);
        bit  p2z = (slice(perm_l2, s) == 2'b00);
        bit  p3z = (slice(perm_l3, s) == 2'b00);
        bit  hsd = halted && has_l3 && sec_dbg_dis && early_undef_opt;
        logic [1:0] l3res = (halted && sec_dbg_dis) ? 2'd1 : 2'd3;
        if (cur_el == 0) return 2'd1;
        if (cur_el == 3) return 2'd0;
        if (hsd && !mon_en_l3) return 2'd1;
        if (hsd && p3z) return 2'd1;
        if (cur_el == 1) begin
            if (l2_enabled && has_fgt && has_l3 && !fgt_en_l3) return 2'd2;
            if (l2_enabled && has_fgt && !fgt_rd_allow) return 2'd2;
            if (l2_enabled && !mon_en_l2) return 2'd2;
            if (l2_enabled && p2z) return 2'd2;
        end
        if (has_l3 && !mon_en_l3) return l3res;
        if (has_l3 && p3z) return l3res;
        return 2'd0;
    endfunction

    function automatic logic [63:0] ref_word();
        int s = int'(inst_sel);
        logic [63:0] w;
        if (s >= N) return 64'h0;
        w = id_words[64*s +: 64];
        w[63:32] = '0;
        w[7] = 1'b0;
        return w;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Issue one request; fields are already set. Response is registered at the
    // next rising edge and sampled 1 ns after it.
    task automatic issue(input string tag);
        logic [1:0]  eo = ref_outcome();
        logic [63:0] ed = (eo == 2'd0) ? ref_word() : 64'h0;
        logic [5:0]  ee = eo[1] ? 6'h18 : 6'h0;
        req_valid = 1'b1;
        @(posedge clk);
        #1;
        chk(tag, "valid", {63'h0, rsp_valid}, 64'h1);
        chk(tag, "outcome", {62'h0, rsp_outcome}, {62'h0, eo});
        chk(tag, "ec", {58'h0, rsp_ec}, {58'h0, ee});
        chk(tag, "data", rsp_data, ed);
        req_valid = 1'b0;
    endtask

    task automatic all_pass();
        halted = 0; sec_dbg_dis = 0; has_l3 = 1; l2_enabled = 1; has_fgt = 1;
        early_undef_opt = 0; fgt_en_l3 = 1; fgt_rd_allow = 1;
        mon_en_l2 = 1; mon_en_l3 = 1; perm_l2 = '1; perm_l3 = '1;
    endtask

    task automatic expect_oc(input string tag, input logic [1:0] exp_oc);
        chk(tag, "directed outcome", {62'h0, ref_outcome()}, {62'h0, exp_oc});
        issue(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        for (int i = 0; i < N; i++) id_words[64*i +: 64] = {$urandom, $urandom};
        repeat (2) @(posedge clk);
        #1;
        // R10: reset state
        chk("R10", "valid", {63'h0, rsp_valid}, 64'h0);
        chk("R10", "outcome", {62'h0, rsp_outcome}, 64'h0);
        chk("R10", "data", rsp_data, 64'h0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R9: idle cycle
        chk("R9", "idle valid", {63'h0, rsp_valid}, 64'h0);
        chk("R9", "idle data", rsp_data, 64'h0);

        all_pass();
        cur_el = 0; expect_oc("R1", 2'd1);
        cur_el = 3; mon_en_l3 = 0; mon_en_l2 = 0; perm_l2 = '0; perm_l3 = '0;
        expect_oc("R2", 2'd0);

        // R8: masking and field layout
        all_pass(); cur_el = 3; inst_sel = 1;
        id_words[64 +: 64] = '1;
        issue("R8");
        chk("R8", "masked all-ones", rsp_data, 64'h0000_0000_FFFF_FF7F);
        id_words[64 +: 64] = 64'hABCD_0000_1234_543B;
        issue("R8");
        chk("R8", "designer code", {52'h0, rsp_data[11:0]}, 64'h43B);
        id_words[64 +: 64] = 64'h0;
        issue("R8");

        // R3: per-instance slice and out-of-range
        all_pass(); cur_el = 1; inst_sel = 2; perm_l2 = 8'b11_00_11_11;
        expect_oc("R3", 2'd2);
        inst_sel = 3; expect_oc("R3", 2'd0);
        inst_sel = 5; cur_el = 3; expect_oc("R3", 2'd0);
        cur_el = 1; perm_l2 = '1; expect_oc("R3", 2'd2);

        // R4: ordering at level 1
        all_pass(); cur_el = 1; inst_sel = 0;
        fgt_en_l3 = 0; mon_en_l3 = 0; expect_oc("R4", 2'd2);
        fgt_en_l3 = 1; fgt_rd_allow = 0; expect_oc("R4", 2'd2);
        fgt_rd_allow = 1; expect_oc("R4", 2'd3);
        mon_en_l3 = 1; perm_l3[1:0] = 2'b00; expect_oc("R4", 2'd3);
        perm_l3 = '1; expect_oc("R4", 2'd0);
        // R7: syndrome class on trap and none on read
        mon_en_l3 = 0; issue("R7");
        chk("R7", "ec on trap-L3", {58'h0, rsp_ec}, 64'h18);

        // R5: level-2 checks skipped
        all_pass(); cur_el = 2; mon_en_l2 = 0; perm_l2 = '0; fgt_rd_allow = 0;
        expect_oc("R5", 2'd0);
        cur_el = 1; l2_enabled = 0; expect_oc("R5", 2'd0);
        mon_en_l3 = 0; expect_oc("R5", 2'd3);

        // R6: halted with secure debug disabled
        all_pass(); cur_el = 1; halted = 1; sec_dbg_dis = 1; mon_en_l3 = 0;
        expect_oc("R6", 2'd1);
        mon_en_l2 = 0; expect_oc("R6", 2'd2);
        early_undef_opt = 1; expect_oc("R6", 2'd1);
        cur_el = 2; has_l3 = 0; expect_oc("R6", 2'd0);

        // Random sweep
        for (int k = 0; k < 4000; k++) begin
            cur_el          = 2'($urandom_range(0, 3));
            halted          = ($urandom_range(0, 3) == 0);
            sec_dbg_dis     = ($urandom_range(0, 1) == 0);
            has_l3          = ($urandom_range(0, 3) != 0);
            l2_enabled      = ($urandom_range(0, 3) != 0);
            has_fgt         = ($urandom_range(0, 1) == 0);
            early_undef_opt = ($urandom_range(0, 1) == 0);
            fgt_en_l3       = ($urandom_range(0, 5) != 0);
            fgt_rd_allow    = ($urandom_range(0, 5) != 0);
            mon_en_l2       = ($urandom_range(0, 5) != 0);
            mon_en_l3       = ($urandom_range(0, 5) != 0);
            perm_l2         = 8'($urandom) | 8'($urandom);
            perm_l3         = 8'($urandom) | 8'($urandom);
            inst_sel        = ($urandom_range(0, 7) == 0) ? SW'($urandom_range(4, 7))
                                                          : SW'($urandom_range(0, 3));
            if ($urandom_range(0, 15) == 0) id_words[64*($urandom_range(0, 3)) +: 64] = '0;
            else id_words[64*($urandom_range(0, 3)) +: 64] = {$urandom, $urandom};
            if (cur_el == 0) issue("R1");
            else if (cur_el == 3) issue("R2");
            else if (halted && sec_dbg_dis) issue("R6");
            else issue("R4");
        end

        @(posedge clk); #1;
        chk("R9", "idle after traffic", {63'h0, rsp_valid}, 64'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule